// File: doc/BRIEF.md
# Drift-Compensated Timestamp Counter

This block keeps a 64-bit nanosecond time value that advances on every reference clock while counting is enabled. Each cycle it adds one of two programmable steps. The base step is the nominal number of nanoseconds per clock. The trim step is a corrected amount that stands in for the base step on selected cycles. Trim cycles come from two sources. A burst count applies the trim step on a fixed number of consecutive cycles, once. A periodic counter applies it once every P cycles, without end. Together they let a servo trim the clock frequency continuously and also apply one-off phase corrections.

Software reaches the block through a simple 32-bit register port. It can program the steps and the compensation controls, load the time, read the time coherently, and clear the wrap flag. The current time is also driven to a port for compare and capture logic. A compare unit can request a synchronous return to zero through a separate input. Each cycle the step selector resolves to one of four kinds, in priority order. HOLD applies while counting is off. BURST applies while the burst count is nonzero. SLOW applies when the periodic counter expires. BASE covers every other cycle.

Top module: `drift_time_counter`

## Requirements
- R1: After reset the time, the wrap flag, the burst count, the period and all control fields are zero, and every register reads 0.
- R2: Register word addresses are control=0, flags=1, burst=2, period=3, time-low=4, time-high=5. In the control word, bit 0 enables counting, bits 7:4 hold the base step and bits 19:8 hold the trim step. All other control bits read as 0. A control write takes effect at the clock edge that performs it, so the first advance happens on the following edge. The edge that writes a 0 to bit 0 still advances.
- R3: While counting is enabled and no compensation applies, the time advances by the base step on each edge. While counting is disabled, the time holds.
- R4: A write to the burst register (bits 23:0 kept, upper bits ignored) sets a count. While it is nonzero, each counting edge adds the trim step and lowers the count by one. Reading the register returns the remaining count.
- R5: A nonzero period P applies the trim step on every P-th counting edge, replacing the base step. A period of 0 disables this, and only base steps are added.
- R6: The periodic counter reloads P when it expires. A write to the period register restarts the count from the written value at once, so the first trim edge is the P-th counting edge after the write.
- R7: The burst path has priority over the periodic path. The periodic counter keeps running during a burst, and an expiry that falls in a burst cycle yields a single trim step, not two.
- R8: A write to time-high only stages the upper word. A write to time-low loads the time with the staged upper word and the written lower word.
- R9: A read returns its data one cycle later with the valid output high. Reading time-low latches the upper half of the same instant, and a later time-high read returns that latched half.
- R10: Bit 0 of the flags register is set when an advance wraps the time past 2^64-1. Writing a 1 to it clears it, and writing a 0 leaves it unchanged.
- R11: The zero request clears the time on the next edge, whether or not counting is enabled, and takes priority over advancing. A time-low write on the same edge takes priority over the zero request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| zero_req | input | 1 | Synchronous clear request from a compare unit |
| time_now | output | 64 | Current time value |

## Verification
The bench aims at the places where the step choice can go subtly wrong.

- Bursts that overlap periodic expiries: a design that added both steps would overshoot, and one that paused the periodic counter during a burst would shift later trims.
- Rewrites of the period in the middle of a cycle: a design without the restart would apply a trim one edge early.
- Time-low reads taken before a carry into the upper word, with the time-high read after it: a design without the latch would return the upper word one too high.
- Wrap through 2^64: a wrong design would miss the flag or clear it on a zero write.
- A zero request that collides with a load: a wrong design would discard the loaded value.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] A_FLAGS  = 3'd1;
    localparam logic [REG_AW-1:0] A_BURST  = 3'd2;
    localparam logic [REG_AW-1:0] A_PERIOD = 3'd3;
    localparam logic [REG_AW-1:0] A_TLO    = 3'd4;
    localparam logic [REG_AW-1:0] A_THI    = 3'd5;

    localparam int RUN_BIT  = 0;
    localparam int BASE_LSB = 4;

    typedef enum logic [1:0] {
        SK_HOLD  = 2'd0,
        SK_BASE  = 2'd1,
        SK_BURST = 2'd2,
        SK_SLOW  = 2'd3
    } step_kind_e;

endpackage

// File: rtl/dtc_regs.sv
module dtc_regs
    import dtc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 64,
    parameter int BASE_W   = 4,
    parameter int TRIM_W   = 12,
    parameter int BURST_W  = 24,
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_rvalid,
    input  logic [CNT_W-1:0]    count_now,
    input  logic                ovf_now,
    input  logic [BURST_W-1:0]  burst_left,
    output logic                run,
    output logic [BASE_W-1:0]   base_step,
    output logic [TRIM_W-1:0]   trim_step,
    output logic [PERIOD_W-1:0] period_val,
    output logic                period_wr,
    output logic                burst_wr,
    output logic [BURST_W-1:0]  burst_wval,
    output logic                load_en,
    output logic [CNT_W-1:0]    load_val,
    output logic                ovf_clr
);

    localparam int HI_W     = CNT_W - DATA_W;
    localparam int TRIM_LSB = BASE_LSB + BASE_W;

    logic [HI_W-1:0]   hi_stage;
    logic [HI_W-1:0]   hi_latch;
    logic [DATA_W-1:0] ctrl_word;

    assign period_wr  = reg_wr && (reg_addr == A_PERIOD);
    assign burst_wr   = reg_wr && (reg_addr == A_BURST);
    assign burst_wval = reg_wdata[BURST_W-1:0];
    assign load_en    = reg_wr && (reg_addr == A_TLO);
    assign load_val   = {hi_stage, reg_wdata};
    assign ovf_clr    = reg_wr && (reg_addr == A_FLAGS) && reg_wdata[0];

    always_comb begin
        ctrl_word = '0;
        ctrl_word[RUN_BIT] = run;
        ctrl_word[BASE_LSB +: BASE_W] = base_step;
        ctrl_word[TRIM_LSB +: TRIM_W] = trim_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run        <= 1'b0;
            base_step  <= '0;
            trim_step  <= '0;
            period_val <= '0;
            hi_stage   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    run       <= reg_wdata[RUN_BIT];
                    base_step <= reg_wdata[BASE_LSB +: BASE_W];
                    trim_step <= reg_wdata[TRIM_LSB +: TRIM_W];
                end
                A_PERIOD: period_val <= reg_wdata[PERIOD_W-1:0];
                A_THI:    hi_stage   <= reg_wdata[HI_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
            hi_latch   <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                case (reg_addr)
                    A_CTRL:   reg_rdata <= ctrl_word;
                    A_FLAGS:  reg_rdata <= {{(DATA_W-1){1'b0}}, ovf_now};
                    A_BURST:  reg_rdata <= {{(DATA_W-BURST_W){1'b0}}, burst_left};
                    A_PERIOD: reg_rdata <= period_val;
                    A_TLO: begin
                        reg_rdata <= count_now[DATA_W-1:0];
                        hi_latch  <= count_now[CNT_W-1:DATA_W];
                    end
                    A_THI:    reg_rdata <= hi_latch;
                    default:  reg_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dtc_step_sel.sv
module dtc_step_sel
    import dtc_pkg::*;
#(
    parameter int BASE_W   = 4,
    parameter int TRIM_W   = 12,
    parameter int BURST_W  = 24,
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [BASE_W-1:0]   base_step,
    input  logic [TRIM_W-1:0]   trim_step,
    input  logic [PERIOD_W-1:0] period_val,
    input  logic                period_wr,
    input  logic [PERIOD_W-1:0] period_wval,
    input  logic                burst_wr,
    input  logic [BURST_W-1:0]  burst_wval,
    output logic [BURST_W-1:0]  burst_left,
    output step_kind_e          step_kind,
    output logic [TRIM_W-1:0]   step_amt
);

    localparam logic [PERIOD_W-1:0] P_ONE = PERIOD_W'(1);
    localparam logic [BURST_W-1:0]  B_ONE = BURST_W'(1);

    logic [PERIOD_W-1:0] slow_q;
    logic                slow_hit;
    logic                period_on;

    assign period_on = (period_val != '0);
    assign slow_hit  = period_on && (slow_q <= P_ONE);

    always_comb begin
        if (!run)
            step_kind = SK_HOLD;
        else if (burst_left != '0)
            step_kind = SK_BURST;
        else if (slow_hit)
            step_kind = SK_SLOW;
        else
            step_kind = SK_BASE;
    end

    always_comb begin
        unique case (step_kind)
            SK_HOLD:          step_amt = '0;
            SK_BASE:          step_amt = {{(TRIM_W-BASE_W){1'b0}}, base_step};
            SK_BURST, SK_SLOW: step_amt = trim_step;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            burst_left <= '0;
        else if (burst_wr)
            burst_left <= burst_wval;
        else if (run && (burst_left != '0))
            burst_left <= burst_left - B_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slow_q <= '0;
        else if (period_wr)
            slow_q <= period_wval;
        else if (run && period_on)
            slow_q <= slow_hit ? period_val : (slow_q - P_ONE);
    end

endmodule

// File: rtl/dtc_accum.sv
module dtc_accum #(
    parameter int CNT_W  = 64,
    parameter int TRIM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              zero_req,
    input  logic              adv,
    input  logic [TRIM_W-1:0] step_amt,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  count_q,
    output logic              ovf_q
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum_w;
    logic             wrap_ev;

    assign sum_w   = {1'b0, count_q} + {{(SUM_W-TRIM_W){1'b0}}, step_amt};
    assign wrap_ev = adv && !load_en && !zero_req && sum_w[CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (load_en)
            count_q <= load_val;
        else if (zero_req)
            count_q <= '0;
        else if (adv)
            count_q <= sum_w[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (wrap_ev)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

endmodule

// File: rtl/drift_time_counter.sv
module drift_time_counter
    import dtc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 64,
    parameter int BASE_W   = 4,
    parameter int TRIM_W   = 12,
    parameter int BURST_W  = 24,
    parameter int PERIOD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              zero_req,
    output logic [CNT_W-1:0]  time_now
);

    logic                run_w;
    logic [BASE_W-1:0]   base_w;
    logic [TRIM_W-1:0]   trim_w;
    logic [PERIOD_W-1:0] period_w;
    logic                period_wr_w;
    logic                burst_wr_w;
    logic [BURST_W-1:0]  burst_wval_w;
    logic [BURST_W-1:0]  burst_left_w;
    logic                load_en_w;
    logic [CNT_W-1:0]    load_val_w;
    logic                ovf_clr_w;
    logic                ovf_w;
    step_kind_e          kind_w;
    logic [TRIM_W-1:0]   step_w;

    dtc_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .BASE_W(BASE_W),
        .TRIM_W(TRIM_W), .BURST_W(BURST_W), .PERIOD_W(PERIOD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .count_now(time_now), .ovf_now(ovf_w), .burst_left(burst_left_w),
        .run(run_w), .base_step(base_w), .trim_step(trim_w),
        .period_val(period_w), .period_wr(period_wr_w),
        .burst_wr(burst_wr_w), .burst_wval(burst_wval_w),
        .load_en(load_en_w), .load_val(load_val_w), .ovf_clr(ovf_clr_w)
    );

    dtc_step_sel #(
        .BASE_W(BASE_W), .TRIM_W(TRIM_W), .BURST_W(BURST_W), .PERIOD_W(PERIOD_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .run(run_w),
        .base_step(base_w), .trim_step(trim_w),
        .period_val(period_w), .period_wr(period_wr_w),
        .period_wval(reg_wdata[PERIOD_W-1:0]),
        .burst_wr(burst_wr_w), .burst_wval(burst_wval_w),
        .burst_left(burst_left_w), .step_kind(kind_w), .step_amt(step_w)
    );

    dtc_accum #(
        .CNT_W(CNT_W), .TRIM_W(TRIM_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en_w), .load_val(load_val_w),
        .zero_req(zero_req), .adv(kind_w != SK_HOLD), .step_amt(step_w),
        .ovf_clr(ovf_clr_w), .count_q(time_now), .ovf_q(ovf_w)
    );

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 64,
    parameter int BURST_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [2:0]         reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               reg_rvalid,
    input logic               zero_req,
    input logic [CNT_W-1:0]   time_now,
    input logic               run,
    input logic [BURST_W-1:0] burst_left,
    input logic               ovf
);

    localparam logic [BURST_W-1:0] B_ONE = BURST_W'(1);

    logic lo_wr;
    logic bu_wr;
    assign lo_wr = reg_wr && (reg_addr == 3'd4);
    assign bu_wr = reg_wr && (reg_addr == 3'd2);

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !lo_wr && !zero_req) |=> $stable(time_now));

    // R11
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req && !lo_wr) |=> (time_now == '0));

    // R8
    low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (time_now[DATA_W-1:0] == $past(reg_wdata)));

    // R9
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    // R4
    burst_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (burst_left != '0) && !bu_wr) |=> (burst_left == $past(burst_left) - B_ONE));

    // R10
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (time_now < $past(time_now)));

endmodule

bind drift_time_counter dtc_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .BURST_W(BURST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .zero_req(zero_req), .time_now(time_now), .run(run_w),
    .burst_left(burst_left_w), .ovf(ovf_w)
);

// File: tb/sim_drift_time_counter.sv
`timescale 1ns/1ps
module sim_drift_time_counter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, zero_req;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [63:0] time_now;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] CTRL_RUN  = 32'h0000_0641;
    localparam logic [31:0] CTRL_STOP = 32'h0000_0640;

    always #2 clk = ~clk;

    drift_time_counter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .zero_req(zero_req), .time_now(time_now)
    );

    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected read data: actual=%h expected=none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] lo);
        wr(3'd5, hi);
        wr(3'd4, lo);
    endtask

    // n idle cycles between start and stop writes: n+1 advances
    task automatic runfor(input int n);
        wr(3'd0, CTRL_RUN);
        idle(n);
        wr(3'd0, CTRL_STOP);
    endtask

    task automatic chk_time(input logic [63:0] e, input string t);
        checks++;
        if (time_now !== e) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", t, time_now, e);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; zero_req = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_time(64'd0, "R1 time after reset");
        rd(3'd0, 32'h0, "R1 control after reset");
        rd(3'd1, 32'h0, "R1 flags after reset");
        rd(3'd2, 32'h0, "R1 burst after reset");
        rd(3'd3, 32'h0, "R1 period after reset");
        rd(3'd4, 32'h0, "R1 time low after reset");

        // R2 field layout and masking
        wr(3'd0, 32'hFFFF_FFFE);
        rd(3'd0, 32'h000F_FFF0, "R2 control unused bits read zero");
        wr(3'd0, CTRL_STOP);

        // R3 base step, holds when stopped
        load(32'h0, 32'h0);
        runfor(5);
        rd(3'd4, 32'd24, "R3 six base advances");
        idle(4);
        rd(3'd4, 32'd24, "R3 holds while stopped");

        // R4 burst
        load(32'h0, 32'h0);
        wr(3'd2, 32'd3);
        rd(3'd2, 32'd3, "R4 burst readback");
        runfor(4);
        rd(3'd4, 32'd26, "R4 three trim then two base");
        rd(3'd2, 32'd0, "R4 burst consumed");
        wr(3'd2, 32'hFF00_0002);
        rd(3'd2, 32'd2, "R4 burst upper bits ignored");
        wr(3'd2, 32'd0);

        // R5 periodic trim
        load(32'h0, 32'h0);
        wr(3'd3, 32'd3);
        rd(3'd3, 32'd3, "R5 period readback");
        runfor(6);
        rd(3'd4, 32'd32, "R5 trim every third edge");
        wr(3'd3, 32'd0);
        load(32'h0, 32'h0);
        runfor(4);
        rd(3'd4, 32'd20, "R5 zero period gives base only");

        // R6 restart and reload
        wr(3'd3, 32'd3);
        load(32'h0, 32'h0);
        runfor(1);
        wr(3'd3, 32'd3);
        runfor(1);
        rd(3'd4, 32'd16, "R6 period write restarts count");
        runfor(0);
        rd(3'd4, 32'd22, "R6 trim on third edge after restart");
        runfor(2);
        rd(3'd4, 32'd36, "R6 reload after expiry");
        wr(3'd3, 32'd0);

        // R7 burst over periodic
        load(32'h0, 32'h0);
        wr(3'd3, 32'd2);
        wr(3'd2, 32'd3);
        runfor(5);
        rd(3'd4, 32'd34, "R7 overlapping expiry single trim");
        wr(3'd3, 32'd0);

        // R8 / R9 load and coherent read
        load(32'h0000_0005, 32'hFFFF_FFF0);
        rd(3'd4, 32'hFFFF_FFF0, "R8 loaded low word");
        rd(3'd5, 32'h0000_0005, "R8 loaded high word");
        wr(3'd0, CTRL_RUN);
        rd(3'd4, 32'hFFFF_FFF0, "R9 low read while running");
        idle(8);
        rd(3'd5, 32'h0000_0005, "R9 high word latched at low read");
        wr(3'd0, CTRL_STOP);
        rd(3'd4, 32'h0000_001C, "R9 low after carry");
        rd(3'd5, 32'h0000_0006, "R9 high after carry");
        wr(3'd5, 32'h0000_0077);
        rd(3'd4, 32'h0000_001C, "R8 high write alone keeps low");
        rd(3'd5, 32'h0000_0006, "R8 high write only staged");

        // R10 wrap flag
        load(32'hFFFF_FFFF, 32'hFFFF_FFF8);
        rd(3'd1, 32'h0, "R10 flag clear before wrap");
        runfor(2);
        rd(3'd4, 32'h0000_0004, "R10 low after wrap");
        rd(3'd5, 32'h0000_0000, "R10 high after wrap");
        rd(3'd1, 32'h1, "R10 flag set by wrap");
        wr(3'd1, 32'h0);
        rd(3'd1, 32'h1, "R10 write zero keeps flag");
        wr(3'd1, 32'h1);
        rd(3'd1, 32'h0, "R10 write one clears flag");

        // R11 zero request
        load(32'h0, 32'h0000_0100);
        wr(3'd0, CTRL_RUN);
        idle(3);
        zero_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        chk_time(64'd0, "R11 cleared on next edge");
        idle(1);
        wr(3'd0, CTRL_STOP);
        rd(3'd4, 32'd8, "R11 counting resumes from zero");
        zero_req = 1'b1;
        wr(3'd4, 32'h0000_1234);
        zero_req = 1'b0;
        chk_time(64'h0000_0000_0000_1234, "R11 low write beats zero request");
        zero_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        chk_time(64'd0, "R11 clears while stopped");

        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9 missing read data: actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule